// File: doc/BRIEF.md
# Compare Timer with Selectable Ceiling

This block is an up-counting timer with two compare channels, meant to sit behind a small register bus in a larger controller. A three-bit source field in the control register chooses what advances the counter: nothing, every system clock, one of four prescaler taps, or an edge of an external pin. The prescaler taps arrive from elsewhere on the chip as single-cycle strobes. The external pin is synchronized and edge-detected inside the block.

The counter counts up to a ceiling and then wraps to zero. The ceiling is either the all-ones value or the value in compare register A. Both compare registers are checked against the counter on every cycle. A match sets a sticky flag for that channel, and the wrap sets a sticky overflow flag. Software clears a flag by writing a one to its bit. The interrupt line is raised while any flag is set whose bit in the mask register is also set.

Top module: `tmr_compare_timer`

## Requirements
- R1: The register map on the 3-bit address is: 0 control, 1 counter, 2 compare A, 3 compare B, 4 flags, 5 mask. The control register holds the source in bits 2:0 and the ceiling select in bit 3. The flag and mask registers use bit 0 for overflow, bit 1 for compare A and bit 2 for compare B. Reads are combinational from the address. After reset, the counter, control, flags and mask read 0, both compare registers read 0xFF, and the interrupt is low.
- R2: With source 000, the counter holds its value whatever the prescaler taps and the external pin do.
- R3: With source 001, the counter advances by one on every clock edge. The first increment lands on the edge after the edge that writes the control register.
- R4: Sources 010, 011, 100 and 101 advance the counter only on a clock edge where tap input bit 0, 1, 2 or 3 respectively is high.
- R5: Source 111 counts rising edges and source 110 counts falling edges of the external pin. A pin change set up before clock edge k shows in the counter after edge k+2 and not earlier. Each pin edge counts once.
- R6: With ceiling select 0 the ceiling is 0xFF. With ceiling select 1 it is compare A. A count event at the ceiling wraps the counter to 0 and sets the overflow flag on that same edge. A counter above compare A keeps counting up to 0xFF and then wraps with overflow.
- R7: On a clock edge where the counter equals compare A, flag bit 1 sets. On a clock edge where it equals compare B, flag bit 2 sets. Both flags stay set.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it alone. If a set condition and a clear happen on the same edge, the flag stays set.
- R9: A counter write loads the written value in place of any count event on that edge. It also suppresses both compare matches on that edge.
- R10: The interrupt output is high exactly when some flag bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| tapStrobe | input | 4 | Prescaler tap strobes, one per division |
| extPin | input | 1 | External count pin, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit counter, four prescaler taps and a two-stage pin synchronizer. At this width, every value of compare A can serve as the ceiling in one sweep, and each run lasts long enough to see its wrap and overflow timing cycle by cycle. Every one of the sixteen tap patterns is applied under each tap source. All eight mask values are tried against two known flag states. The narrow synchronizer makes the exact two-edge pin latency observable.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CNT_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 3;
  localparam int NUM_TAPS = 4;
  localparam int NUM_CMP  = 2;
  localparam int FLAG_W   = NUM_CMP + 1;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd5;

  // flag bit positions
  localparam int FLG_OVF  = 0;
  localparam int FLG_CMPA = 1;
  localparam int FLG_CMPB = 2;

  // source encodings
  localparam logic [SEL_W-1:0] SRC_STOP = 3'd0;
  localparam logic [SEL_W-1:0] SRC_SYS  = 3'd1;
  localparam logic [SEL_W-1:0] SRC_TAP0 = 3'd2;
  localparam logic [SEL_W-1:0] SRC_FALL = 3'd6;
  localparam logic [SEL_W-1:0] SRC_RISE = 3'd7;

  // control-to-datapath strobes
  typedef struct packed {
    logic              countEn;
    logic              cntLoad;
    logic [CNT_W-1:0]  loadVal;
    logic [FLAG_W-1:0] flagClr;
    logic              topSel;
    logic [CNT_W-1:0]  cmpA;
    logic [CNT_W-1:0]  cmpB;
  } ctrlStrobes_t;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic riseEv,
  output logic fallEv
);

  logic [STAGES-1:0] syncQ;
  logic              lastQ;
  logic              syncOut;

  // synchronizer chain, one flop per stage
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  assign syncOut = syncQ[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncOut;
  end

  assign riseEv = syncOut & ~lastQ;
  assign fallEv = ~syncOut & lastQ;

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [CNT_W-1:0]     busWdata,
  output logic [CNT_W-1:0]     busRdata,
  input  logic [NUM_TAPS-1:0]  tapStrobe,
  input  logic                 extPin,
  input  logic [CNT_W-1:0]     cntQ,
  input  logic [FLAG_W-1:0]    flagQ,
  output logic [SEL_W-1:0]     clkSelQ,
  output logic [FLAG_W-1:0]    maskQ,
  output ctrlStrobes_t         strobes
);

  logic             topSelQ;
  logic [CNT_W-1:0] cmpAQ;
  logic [CNT_W-1:0] cmpBQ;
  logic             riseEv;
  logic             fallEv;
  logic             tapHit;
  logic             countEn;
  logic             wrCnt;
  logic             wrFlag;

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (extPin),
    .riseEv(riseEv),
    .fallEv(fallEv)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelQ <= SRC_STOP;
      topSelQ <= 1'b0;
      cmpAQ   <= '1;
      cmpBQ   <= '1;
      maskQ   <= '0;
    end else if (busWr) begin
      case (busAddr)
        A_CTRL: begin
          clkSelQ <= busWdata[SEL_W-1:0];
          topSelQ <= busWdata[SEL_W];
        end
        A_CMPA:  cmpAQ <= busWdata;
        A_CMPB:  cmpBQ <= busWdata;
        A_MASK:  maskQ <= busWdata[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  // tap selection
  always_comb begin
    tapHit = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (clkSelQ == SEL_W'(i + 2)) tapHit = tapStrobe[i];
    end
  end

  // source selection
  always_comb begin
    case (clkSelQ)
      SRC_STOP: countEn = 1'b0;
      SRC_SYS:  countEn = 1'b1;
      SRC_FALL: countEn = fallEv;
      SRC_RISE: countEn = riseEv;
      default:  countEn = tapHit;
    endcase
  end

  assign wrCnt  = busWr && (busAddr == A_CNT);
  assign wrFlag = busWr && (busAddr == A_FLAG);

  always_comb begin
    strobes.countEn = countEn;
    strobes.cntLoad = wrCnt;
    strobes.loadVal = busWdata;
    strobes.flagClr = wrFlag ? busWdata[FLAG_W-1:0] : '0;
    strobes.topSel  = topSelQ;
    strobes.cmpA    = cmpAQ;
    strobes.cmpB    = cmpBQ;
  end

  // register readback
  always_comb begin
    case (busAddr)
      A_CTRL:  busRdata = CNT_W'({topSelQ, clkSelQ});
      A_CNT:   busRdata = cntQ;
      A_CMPA:  busRdata = cmpAQ;
      A_CMPB:  busRdata = cmpBQ;
      A_FLAG:  busRdata = CNT_W'(flagQ);
      A_MASK:  busRdata = CNT_W'(maskQ);
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  output logic [CNT_W-1:0]  cntQ,
  output logic [FLAG_W-1:0] flagQ
);

  localparam logic [CNT_W-1:0] MAX_VAL = '1;

  logic [CNT_W-1:0]   topVal;
  logic               atWrap;
  logic               ovfEv;
  logic [CNT_W-1:0]   cmpVal [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [FLAG_W-1:0]  setVec;

  assign topVal = strobes.topSel ? strobes.cmpA : MAX_VAL;
  assign atWrap = (cntQ == topVal) || (cntQ == MAX_VAL);
  assign ovfEv  = strobes.countEn && !strobes.cntLoad && atWrap;

  assign cmpVal[0] = strobes.cmpA;
  assign cmpVal[1] = strobes.cmpB;

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign hit[g] = (cntQ == cmpVal[g]) && !strobes.cntLoad;
  end

  assign setVec = {hit, ovfEv};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobes.cntLoad) begin
      cntQ <= strobes.loadVal;
    end else if (strobes.countEn) begin
      cntQ <= atWrap ? '0 : cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~strobes.flagClr) | setVec;
  end

endmodule

// File: rtl/tmr_compare_timer.sv
module tmr_compare_timer
  import tmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CNT_W-1:0]    busWdata,
  output logic [CNT_W-1:0]    busRdata,
  input  logic [NUM_TAPS-1:0] tapStrobe,
  input  logic                extPin,
  output logic                irq
);

  ctrlStrobes_t      strobes;
  logic [CNT_W-1:0]  cntQ;
  logic [FLAG_W-1:0] flagQ;
  logic [FLAG_W-1:0] maskQ;
  logic [SEL_W-1:0]  clkSelQ;

  tmr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tapStrobe(tapStrobe),
    .extPin   (extPin),
    .cntQ     (cntQ),
    .flagQ    (flagQ),
    .clkSelQ  (clkSelQ),
    .maskQ    (maskQ),
    .strobes  (strobes)
  );

  tmr_datapath dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cntQ   (cntQ),
    .flagQ  (flagQ)
  );

  assign irq = |(flagQ & maskQ);

endmodule

// File: rtl/tmr_compare_timer_chk.sv
module tmr_compare_timer_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [CNT_W-1:0]  busWdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cntQ,
  input logic [FLAG_W-1:0] flagQ,
  input logic [SEL_W-1:0]  clkSelQ
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic cntWrite;
  logic flagWrite;
  assign cntWrite  = busWr && (busAddr == A_CNT);
  assign flagWrite = busWr && (busAddr == A_FLAG);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSelQ == SRC_STOP && !cntWrite) |=> $stable(cntQ));

  // R9
  load_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntWrite |=> (cntQ == $past(busWdata)));

  // R6
  ovf_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[FLG_OVF]) |-> (cntQ == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cntWrite |=> (cntQ == $past(cntQ) || cntQ == $past(cntQ) + ONE || cntQ == '0));

  // R8
  for (genvar g = 0; g < FLAG_W; g++) begin : g_sticky
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[g] && !(flagWrite && busWdata[g])) |=> flagQ[g]);
  end

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ != '0));

endmodule

bind tmr_compare_timer tmr_compare_timer_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .irq     (irq),
  .cntQ    (cntQ),
  .flagQ   (flagQ),
  .clkSelQ (clkSelQ)
);

// File: tb/tmr_compare_timer_tb_top.sv
module tmr_compare_timer_tb_top;
  import tmr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                busWr = 1'b0;
  logic [ADDR_W-1:0]   busAddr = '0;
  logic [CNT_W-1:0]    busWdata = '0;
  logic [CNT_W-1:0]    busRdata;
  logic [NUM_TAPS-1:0] tapStrobe = '0;
  logic                extPin = 1'b0;
  logic                irq;

  int vecCnt = 0;
  int missCnt = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_compare_timer dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .tapStrobe(tapStrobe),
    .extPin   (extPin),
    .irq      (irq)
  );

  task automatic check(input string req, input int act, input int expV);
    vecCnt++;
    if (act != expV) begin
      missCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expV);
    end
  endtask

  // called at a falling edge, returns at the next falling edge
  task automatic wrReg(input logic [ADDR_W-1:0] a, input int d);
    busWr = 1'b1;
    busAddr = a;
    busWdata = CNT_W'(d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output int v);
    busAddr = a;
    #1;
    v = int'(busRdata);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    int v;
    int expCnt;
    int expFlg;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    rdReg(A_CTRL, v); check("R1 ctrl", v, 0);
    rdReg(A_CNT, v);  check("R1 cnt", v, 0);
    rdReg(A_CMPA, v); check("R1 cmpA", v, 255);
    rdReg(A_CMPB, v); check("R1 cmpB", v, 255);
    rdReg(A_FLAG, v); check("R1 flags", v, 0);
    rdReg(A_MASK, v); check("R1 mask", v, 0);
    check("R1 irq", int'(irq), 0);

    // R2 stopped source ignores taps and pin
    for (int i = 0; i < 20; i++) begin
      tapStrobe = NUM_TAPS'(i);
      extPin = i[1];
      step(1);
    end
    tapStrobe = '0;
    extPin = 1'b0;
    step(4);
    rdReg(A_CNT, v); check("R2 frozen", v, 0);

    // R3/R6 sweep of every compare-A ceiling with system clock
    for (int top = 0; top < 256; top++) begin
      wrReg(A_CTRL, 8'h08);
      wrReg(A_CMPA, top);
      wrReg(A_CNT, 0);
      wrReg(A_FLAG, 1);
      wrReg(A_CTRL, 8'h09);
      rdReg(A_CNT, v); check("R3 first edge", v, 0);
      expCnt = 0;
      expFlg = 0;
      for (int i = 0; i < top + 3; i++) begin
        step(1);
        if (expCnt == top) begin
          expCnt = 0;
          expFlg = 1;
        end else begin
          expCnt++;
        end
        rdReg(A_CNT, v);  check("R6 ceiling count", v, expCnt);
        rdReg(A_FLAG, v); check("R6 overflow flag", v & 1, expFlg);
      end
    end

    // R6 counter above the ceiling runs to all-ones
    wrReg(A_CTRL, 8'h08);
    wrReg(A_CMPA, 10);
    wrReg(A_CNT, 250);
    wrReg(A_FLAG, 1);
    wrReg(A_CTRL, 8'h09);
    step(5);
    rdReg(A_CNT, v);  check("R6 above top max", v, 255);
    rdReg(A_FLAG, v); check("R6 above top no ovf", v & 1, 0);
    step(1);
    rdReg(A_CNT, v);  check("R6 above top wrap", v, 0);
    rdReg(A_FLAG, v); check("R6 above top ovf", v & 1, 1);

    // R7 compare flag timing, ceiling 0xFF
    for (int p = 0; p < 3; p++) begin
      int ca;
      int cb;
      ca = (p == 0) ? 10 : (p == 1) ? 200 : 77;
      cb = (p == 0) ? 20 : (p == 1) ? 3 : 77;
      wrReg(A_CTRL, 0);
      wrReg(A_CMPA, ca);
      wrReg(A_CMPB, cb);
      wrReg(A_CNT, 0);
      wrReg(A_FLAG, 7);
      wrReg(A_CTRL, 1);
      expCnt = 0;
      expFlg = 0;
      for (int i = 0; i < 300; i++) begin
        step(1);
        if (expCnt == ca) expFlg = expFlg | 2;
        if (expCnt == cb) expFlg = expFlg | 4;
        if (expCnt == 255) begin
          expCnt = 0;
          expFlg = expFlg | 1;
        end else begin
          expCnt++;
        end
        rdReg(A_CNT, v);  check("R7 count", v, expCnt);
        rdReg(A_FLAG, v); check("R7 flags", v, expFlg);
      end
    end

    // R10 mask sweep with all flags set, then overflow cleared
    wrReg(A_CTRL, 0);
    wrReg(A_CNT, 5);
    for (int m = 0; m < 8; m++) begin
      wrReg(A_MASK, m);
      check("R10 irq all flags", int'(irq), ((7 & m) != 0) ? 1 : 0);
    end
    wrReg(A_FLAG, 1);
    rdReg(A_FLAG, v); check("R8 clear one bit", v, 6);
    for (int m = 0; m < 8; m++) begin
      wrReg(A_MASK, m);
      check("R10 irq two flags", int'(irq), ((6 & m) != 0) ? 1 : 0);
    end

    // R8 set wins over clear while parked on compare A
    wrReg(A_CNT, 77);
    wrReg(A_FLAG, 2);
    rdReg(A_FLAG, v); check("R8 set wins", v, 6);
    wrReg(A_CNT, 5);
    wrReg(A_FLAG, 6);
    rdReg(A_FLAG, v); check("R8 clear all", v, 0);
    wrReg(A_MASK, 0);
    check("R10 irq none", int'(irq), 0);

    // R9 counter write suppresses the match on its edge
    wrReg(A_CMPB, 5);
    wrReg(A_CNT, 70);
    rdReg(A_FLAG, v); check("R9 match blocked", v, 0);
    rdReg(A_CNT, v);  check("R9 loaded", v, 70);
    wrReg(A_CMPB, 70);
    step(1);
    rdReg(A_FLAG, v); check("R7 match B", v, 4);
    wrReg(A_CTRL, 1);
    wrReg(A_CNT, 100);
    rdReg(A_CNT, v); check("R9 load beats count", v, 100);
    step(1);
    rdReg(A_CNT, v); check("R9 count resumes", v, 101);

    // R4 every tap pattern under every tap source
    for (int sel = 2; sel < 6; sel++) begin
      wrReg(A_CTRL, 0);
      wrReg(A_CNT, 0);
      wrReg(A_CTRL, sel);
      expCnt = 0;
      for (int p = 0; p < 16; p++) begin
        tapStrobe = NUM_TAPS'(p);
        step(1);
        tapStrobe = '0;
        expCnt = expCnt + ((p >> (sel - 2)) & 1);
        rdReg(A_CNT, v); check("R4 tap count", v, expCnt);
      end
    end

    // R5 rising edges of the pin
    wrReg(A_CTRL, 0);
    wrReg(A_CNT, 0);
    extPin = 1'b0;
    step(4);
    wrReg(A_CTRL, 7);
    expCnt = 0;
    for (int k = 0; k < 3; k++) begin
      extPin = 1'b1;
      step(2);
      rdReg(A_CNT, v); check("R5 rise latency", v, expCnt);
      step(1);
      expCnt++;
      rdReg(A_CNT, v); check("R5 rise counted", v, expCnt);
      step(3);
      rdReg(A_CNT, v); check("R5 rise once", v, expCnt);
      extPin = 1'b0;
      step(4);
      rdReg(A_CNT, v); check("R5 fall ignored", v, expCnt);
    end

    // R5 falling edges of the pin
    wrReg(A_CTRL, 6);
    for (int k = 0; k < 3; k++) begin
      extPin = 1'b1;
      step(4);
      rdReg(A_CNT, v); check("R5 rise ignored", v, expCnt);
      extPin = 1'b0;
      step(2);
      rdReg(A_CNT, v); check("R5 fall latency", v, expCnt);
      step(1);
      expCnt++;
      rdReg(A_CNT, v); check("R5 fall counted", v, expCnt);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule